// File: doc/BRIEF.md
# Banked Non-Blocking Direct-Mapped Read Cache

This block holds the lookup and miss-tracking state of a read-only, byte-addressed data cache with 32-bit addresses. Storage of 16 KB is split into four independent banks of 4 KB, each direct-mapped with 16-byte lines. Every bank owns a single miss tracker. A miss to one bank is accepted and sent to memory while the other banks keep serving hits and accepting their own misses. A second miss to a bank whose tracker is occupied is held off through `req_ready`.

The processor presents `req_valid` and `req_addr`. The request is consumed on a clock edge where `req_ready` is high. An accepted hit returns the whole line on `hit_data` one cycle later. An accepted miss claims the bank's tracker and raises a one-cycle memory read request for the aligned line one cycle later. The line's tag is rewritten at once and the line stays unusable until its data returns. Memory returns lines on the fill port, tagged with the bank number and in any order across banks. Each accepted fill writes the line, frees the tracker and reports the original byte address and line data on the completion outputs one cycle later.

Top module: `nbcache_core`

## Requirements
- R1: Address fields are byte offset `[3:0]`, bank `[5:4]`, line index `[13:6]` and tag `[31:14]`. The memory request address is the request address with bits `[3:0]` cleared.
- R2: After reset no line is valid, so the first read to any address is a miss, and `hit_valid`, `mem_req_valid` and `done_valid` are low.
- R3: A miss to a bank with a free tracker has `req_ready` high in the same cycle. `mem_req_valid` is then high for exactly the following cycle, carrying the line address.
- R4: A miss to a bank whose tracker is occupied drives `req_ready` low and issues no memory request.
- R5: While one bank's tracker is occupied, misses to the other banks are accepted and sent to memory.
- R6: A fill to a bank with an occupied tracker writes the line and frees the tracker. One cycle later `done_valid` is high with `done_addr` equal to the original byte address and `done_data` equal to the fill data.
- R7: A read to a valid line with a matching tag is accepted. One cycle later `hit_valid` is high and `hit_data` holds that line, with no memory request.
- R8: A read to a line whose fill is still outstanding stalls (`req_ready` low), even when its tag matches the pending tag.
- R9: Fills to different banks may arrive in any order. Each completes only its own bank's tracker.
- R10: A fill to a bank whose tracker is free is ignored. It gives no completion and leaves that bank's lines invalid, so a later read there still misses.
- R11: A miss that allocates a line overwrites its tag. A later read with the old tag to the same bank and index is a miss.
- R12: A hit to a bank whose tracker is occupied by a different line is served without stalling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_addr | input | 32 | Read byte address |
| req_ready | output | 1 | Request is accepted this cycle (low = stall) |
| hit_valid | output | 1 | Hit data returned |
| hit_data | output | 128 | Line of the hit |
| mem_req_valid | output | 1 | Memory line read request (one cycle) |
| mem_req_addr | output | 32 | Aligned line address for memory |
| fill_valid | input | 1 | Line returned from memory |
| fill_bank | input | 2 | Bank that the returned line belongs to |
| fill_data | input | 128 | Returned line data |
| done_valid | output | 1 | A miss has completed |
| done_addr | output | 32 | Byte address of the completed miss |
| done_data | output | 128 | Line data of the completed miss |

## Verification
The hardest case to reach is a hit served from a bank while that same bank's tracker waits on a different index. A plain hit, a plain miss or a stall does not show it. The stimulus first fills one line of bank 0, then opens a miss on the neighbouring index of bank 0, and reads the first line before that fill returns. Out-of-order fills and an ignored fill to an idle bank are also driven. The bank that received the ignored fill is then read, to show its line still misses.

// File: rtl/nbc_pkg.sv
// Package: shared types of the banked read cache.
// Assumes: nothing beyond standard SystemVerilog.
package nbc_pkg;

    // Result of looking up one request in its bank
    typedef enum logic [1:0] {
        LK_HIT   = 2'd0,
        LK_ALLOC = 2'd1,
        LK_STALL = 2'd2
    } lk_outcome_e;

endpackage

// File: rtl/nbc_decode.sv
// Module: splits a byte address into offset, bank, index and tag fields.
// Assumes: the widths sum to ADDR_W; fields are ordered tag|index|bank|offset.
module nbc_decode #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int BANK_W = 2,
    parameter int IDX_W  = 8,
    localparam int TAG_W = ADDR_W - IDX_W - BANK_W - OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [OFF_W-1:0]  off,
    output logic [BANK_W-1:0] bank,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag
);

    // Field extraction from the low end upward
    always_comb begin
        off  = addr[OFF_W-1:0];
        bank = addr[OFF_W+BANK_W-1:OFF_W];
        idx  = addr[OFF_W+BANK_W+IDX_W-1:OFF_W+BANK_W];
        tag  = addr[ADDR_W-1:OFF_W+BANK_W+IDX_W];
    end

endmodule

// File: rtl/nbc_bank.sv
// Module: one direct-mapped bank with tag, valid and data arrays and a
// single miss tracker.
// Assumes: at most one request and one fill per cycle. An allocation only
// happens with the tracker free and a fill is only taken with it occupied,
// so the two never write in the same cycle.
module nbc_bank
    import nbc_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int TAG_W  = 18,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 128,
    localparam int LINES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic [OFF_W-1:0]  off,
    output lk_outcome_e       outcome,
    output logic [DATA_W-1:0] rd_data,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    output logic              fill_take,
    output logic [TAG_W-1:0]  pend_tag,
    output logic [IDX_W-1:0]  pend_idx,
    output logic [OFF_W-1:0]  pend_off
);

    logic [TAG_W-1:0]  tag_q [LINES];
    logic [DATA_W-1:0] dat_q [LINES];
    logic [LINES-1:0]  vld_q;
    logic              busy_q;
    logic [IDX_W-1:0]  m_idx_q;
    logic [TAG_W-1:0]  m_tag_q;
    logic [OFF_W-1:0]  m_off_q;
    logic              alloc;
    logic              tag_hit;
    logic              pend_same;

    // Lookup: classify the request as hit, allocation or stall
    always_comb begin
        tag_hit   = vld_q[idx] && (tag_q[idx] == tag);
        pend_same = busy_q && (m_idx_q == idx);
        if (tag_hit && !pend_same) outcome = LK_HIT;
        else if (!busy_q)          outcome = LK_ALLOC;
        else                       outcome = LK_STALL;
    end

    assign alloc     = req_en && (outcome == LK_ALLOC);
    assign fill_take = fill_en && busy_q;
    assign rd_data   = dat_q[idx];
    assign pend_tag  = m_tag_q;
    assign pend_idx  = m_idx_q;
    assign pend_off  = m_off_q;

    // Tag and data arrays: tag rewritten on allocation, data on fill
    always_ff @(posedge clk) begin
        if (alloc)     tag_q[idx]     <= tag;
        if (fill_take) dat_q[m_idx_q] <= fill_data;
    end

    // Valid bits: cleared at reset and on allocation, set by the fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            if (alloc)     vld_q[idx]     <= 1'b0;
            if (fill_take) vld_q[m_idx_q] <= 1'b1;
        end
    end

    // Miss tracker: claimed by an allocation, released by the fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            m_idx_q <= '0;
            m_tag_q <= '0;
            m_off_q <= '0;
        end else if (alloc) begin
            busy_q  <= 1'b1;
            m_idx_q <= idx;
            m_tag_q <= tag;
            m_off_q <= off;
        end else if (fill_take) begin
            busy_q  <= 1'b0;
        end
    end

endmodule

// File: rtl/nbcache_core.sv
// Module: top of the banked non-blocking read cache. Decodes the request,
// steers it to its bank, registers the hit response, the memory request
// and the miss completion.
// Assumes: memory accepts every request pulse, and fill_bank names a bank
// whose tracker holds the returning line.
module nbcache_core
    import nbc_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 16384,
    parameter int NUM_BANKS   = 4,
    parameter int LINE_BYTES  = 16,
    localparam int OFF_W      = $clog2(LINE_BYTES),
    localparam int BANK_W     = $clog2(NUM_BANKS),
    localparam int LINES      = CACHE_BYTES / (NUM_BANKS * LINE_BYTES),
    localparam int IDX_W      = $clog2(LINES),
    localparam int TAG_W      = ADDR_W - IDX_W - BANK_W - OFF_W,
    localparam int DATA_W     = LINE_BYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              hit_valid,
    output logic [DATA_W-1:0] hit_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              fill_valid,
    input  logic [BANK_W-1:0] fill_bank,
    input  logic [DATA_W-1:0] fill_data,
    output logic              done_valid,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] done_data
);

    logic [OFF_W-1:0]  r_off;
    logic [BANK_W-1:0] r_bank;
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;

    lk_outcome_e       outc_v  [NUM_BANKS];
    logic [DATA_W-1:0] rd_v    [NUM_BANKS];
    logic [TAG_W-1:0]  ptag_v  [NUM_BANKS];
    logic [IDX_W-1:0]  pidx_v  [NUM_BANKS];
    logic [OFF_W-1:0]  poff_v  [NUM_BANKS];
    logic [NUM_BANKS-1:0] take_v;

    lk_outcome_e outc;
    logic        accept;

    nbc_decode #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .BANK_W (BANK_W),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr (req_addr),
        .off  (r_off),
        .bank (r_bank),
        .idx  (r_idx),
        .tag  (r_tag)
    );

    // One bank instance per bank number, each with its own tracker
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        nbc_bank #(
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .OFF_W  (OFF_W),
            .DATA_W (DATA_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req_en    (req_valid && (r_bank == BANK_W'(b))),
            .idx       (r_idx),
            .tag       (r_tag),
            .off       (r_off),
            .outcome   (outc_v[b]),
            .rd_data   (rd_v[b]),
            .fill_en   (fill_valid && (fill_bank == BANK_W'(b))),
            .fill_data (fill_data),
            .fill_take (take_v[b]),
            .pend_tag  (ptag_v[b]),
            .pend_idx  (pidx_v[b]),
            .pend_off  (poff_v[b])
        );
    end

    assign outc      = outc_v[r_bank];
    assign req_ready = (outc != LK_STALL);
    assign accept    = req_valid && req_ready;

    // Response and memory request registers for the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_valid     <= 1'b0;
            mem_req_valid <= 1'b0;
            mem_req_addr  <= '0;
            hit_data      <= '0;
        end else begin
            hit_valid     <= accept && (outc == LK_HIT);
            mem_req_valid <= accept && (outc == LK_ALLOC);
            mem_req_addr  <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            hit_data      <= rd_v[r_bank];
        end
    end

    // Completion register: reports the miss released by an accepted fill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_addr  <= '0;
            done_data  <= '0;
        end else begin
            done_valid <= take_v[fill_bank];
            done_addr  <= {ptag_v[fill_bank], pidx_v[fill_bank], fill_bank, poff_v[fill_bank]};
            done_data  <= fill_data;
        end
    end

endmodule

// File: rtl/nbc_checker.sv
// Module: temporal checks on the cache ports, bound to nbcache_core.
// Assumes: synchronous active-low reset; checks are off while it is low.
module nbc_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              hit_valid,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              fill_valid,
    input logic              done_valid
);

    // R1: memory requests are line aligned
    p_line_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));

    // R3: a memory request follows an accepted request
    p_memreq_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> $past(req_valid && req_ready));

    // R4: a stalled request never produces a memory request
    p_stall_no_memreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> !mem_req_valid);

    // R6: a completion follows a fill
    p_done_after_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(fill_valid));

    // R7: a hit response follows an accepted request
    p_hit_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_valid |-> $past(req_valid && req_ready));

    // R7: a hit and a memory request never stem from the same request
    p_hit_excl_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_valid && mem_req_valid));

endmodule

bind nbcache_core nbc_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .hit_valid     (hit_valid),
    .mem_req_valid (mem_req_valid),
    .mem_req_addr  (mem_req_addr),
    .fill_valid    (fill_valid),
    .done_valid    (done_valid)
);

// File: tb/sim_nbcache_core.sv
// Bench: scoreboard for nbcache_core. Driver tasks queue expected results;
// a monitor on the falling edge pops and compares them.
module sim_nbcache_core;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_addr = '0;
    logic         req_ready;
    logic         hit_valid;
    logic [127:0] hit_data;
    logic         mem_req_valid;
    logic [31:0]  mem_req_addr;
    logic         fill_valid = 1'b0;
    logic [1:0]   fill_bank = '0;
    logic [127:0] fill_data = '0;
    logic         done_valid;
    logic [31:0]  done_addr;
    logic [127:0] done_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [127:0] hit_q[$];
    string        hit_r[$];
    logic [31:0]  mem_q[$];
    string        mem_r[$];
    logic [31:0]  dna_q[$];
    logic [127:0] dnd_q[$];
    string        dn_r[$];

    always #4 clk = ~clk;

    nbcache_core u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_ready(req_ready), .hit_valid(hit_valid), .hit_data(hit_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .fill_valid(fill_valid), .fill_bank(fill_bank), .fill_data(fill_data),
        .done_valid(done_valid), .done_addr(done_addr), .done_data(done_data)
    );

    // Line contents of a memory address as the bench's memory holds them
    function automatic logic [127:0] line_val(input logic [31:0] a);
        logic [31:0] la;
        la = {a[31:4], 4'h0};
        return {la ^ 32'h1357_9BDF, la ^ 32'h2468_ACE0, la ^ 32'hF0E1_D2C3, la ^ 32'h0F1E_2D3C};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // kind: 0 = hit, 1 = miss accepted, 2 = stall
    task automatic rd(input logic [31:0] a, input int kind, input string rq);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        check(req_ready == (kind != 2), rq, 128'(req_ready), 128'(kind != 2));
        if (kind == 0) begin hit_q.push_back(line_val(a)); hit_r.push_back(rq); end
        if (kind == 1) begin mem_q.push_back({a[31:4], 4'h0}); mem_r.push_back(rq); end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Fill a line; when taken, expect completion for the original address
    task automatic fill(input logic [1:0] b, input logic [31:0] a, input bit taken, input string rq);
        fill_valid = 1'b1;
        fill_bank  = b;
        fill_data  = line_val(a);
        if (taken) begin dna_q.push_back(a); dnd_q.push_back(line_val(a)); dn_r.push_back(rq); end
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Monitor: compares every produced result with the queued expectation
    always @(negedge clk) begin
        if (rst_n) begin
            if (hit_valid) begin
                if (hit_q.size() == 0) check(1'b0, "R4 unexpected hit", 128'(1), 128'(0));
                else check(hit_data == hit_q[0], hit_r[0], hit_data, hit_q[0]);
                if (hit_q.size() != 0) begin void'(hit_q.pop_front()); void'(hit_r.pop_front()); end
            end
            if (mem_req_valid) begin
                if (mem_q.size() == 0) check(1'b0, "R4 unexpected memory request", 128'(mem_req_addr), 128'(0));
                else check(mem_req_addr == mem_q[0], mem_r[0], 128'(mem_req_addr), 128'(mem_q[0]));
                if (mem_q.size() != 0) begin void'(mem_q.pop_front()); void'(mem_r.pop_front()); end
            end
            if (done_valid) begin
                if (dna_q.size() == 0) check(1'b0, "R10 unexpected completion", 128'(done_addr), 128'(0));
                else begin
                    check(done_addr == dna_q[0], dn_r[0], 128'(done_addr), 128'(dna_q[0]));
                    check(done_data == dnd_q[0], dn_r[0], done_data, dnd_q[0]);
                    void'(dna_q.pop_front()); void'(dnd_q.pop_front()); void'(dn_r.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R2: quiet outputs after reset
        check(!hit_valid && !mem_req_valid && !done_valid, "R2 reset outputs",
              128'({hit_valid, mem_req_valid, done_valid}), 128'(0));

        rd(32'h0000_1000, 1, "R2 R3 first read misses, bank 0 line 0x40");
        rd(32'h0000_1020, 1, "R5 miss to bank 2 proceeds");
        rd(32'h0000_1040, 2, "R4 second miss to busy bank 0 stalls");
        rd(32'h0000_1008, 2, "R8 read to pending line stalls");
        fill(2'd3, 32'h0000_0030, 1'b0, "R10 fill to idle bank ignored");
        fill(2'd2, 32'h0000_1020, 1'b1, "R9 bank 2 fill returns first");
        fill(2'd0, 32'h0000_1000, 1'b1, "R6 bank 0 fill completes miss");
        rd(32'h0000_1004, 0, "R7 hit after fill");
        rd(32'h0000_1020, 0, "R7 hit in bank 2");
        rd(32'h0000_1040, 1, "R3 bank 0 freed, new miss index 0x41");
        rd(32'h0000_100C, 0, "R12 hit while bank 0 tracks another line");
        rd(32'h0000_2030, 1, "R10 bank 3 still misses after ignored fill");
        fill(2'd3, 32'h0000_2030, 1'b1, "R6 bank 3 completion");
        fill(2'd0, 32'h0000_1040, 1'b1, "R6 bank 0 second completion");
        rd(32'h0001_1000, 1, "R11 conflicting tag allocates bank 0 line 0x40");
        fill(2'd0, 32'h0001_1000, 1'b1, "R6 conflicting line completion");
        rd(32'h0000_1000, 1, "R11 old tag now misses");
        fill(2'd0, 32'h0000_1000, 1'b1, "R6 refill completion");
        rd(32'h0000_1000, 0, "R7 refilled line hits");
        rd(32'h0001_1004, 1, "R11 evicted tag misses again");
        fill(2'd0, 32'h0001_1004, 1'b1, "R6 refill of evicted tag");
        rd(32'hFFFF_C3F4, 1, "R1 high tag, bank 3 index 0x0F, aligned request");
        fill(2'd3, 32'hFFFF_C3F4, 1'b1, "R1 completion keeps byte address");
        rd(32'hFFFF_C3F8, 0, "R1 same line other offset hits");
        repeat (3) @(negedge clk);
        check(hit_q.size() == 0 && mem_q.size() == 0 && dna_q.size() == 0,
              "R3 R6 R7 all expected results seen",
              128'(hit_q.size() + mem_q.size() + dna_q.size()), 128'(0));
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule